// File: doc/BRIEF.md
# Remote Terminal Reset Mode-Code Handler

This block sits behind the command decoder of a serial-bus remote terminal. It reacts to one mode command, the terminal reset. Each decoded command arrives as a single-cycle strobe. The decoder supplies a word-valid flag, the transmit/receive bit, the five-bit mode code, a broadcast flag, the bus the command arrived on, the terminal's illegal-command table bit for this command, the option bit that invalidates undefined mode codes, and a flag that says a data word followed the command without a gap.

From these inputs the block picks one of five outcomes: ignored, gap error, in-form, illegal or reset. For each outcome it produces four kinds of result:
- the status bits it owns: message error, busy and broadcast received;
- the descriptor control bits and the message information bits that a memory writer stores;
- the interrupt strobes;
- a request to transmit the status word.

A reset outcome also arms a deferred clear. When the status transmission ends, the deferred clear empties the status bits, the built-in-test word, the transmitter shutdown bits and the terminal-flag inhibit. When the status reply is suppressed, the clear waits for the end of the message instead.

The host-side set inputs stand in for the rest of the terminal: busy, shutdown, flag inhibit and the loading of the built-in-test word.

Top module: `rt_reset_mc`

## Requirements
- R1: The block reacts only to a strobed command with mode code 5'b01000. With any other code, or with the word-valid flag low, no output and no held state changes.
- R2: A strobe with transmit/receive = 0 and invalidation option = 1 changes nothing and raises nothing. This holds whatever the table bit and broadcast flag are.
- R3: When a data word follows a valid command, whatever its transmit/receive and option bits, the outcome is a gap error:
  - message error is set and no status transmit is requested;
  - the descriptor shows busy-access = 1 and broadcast = 0;
  - the info bits show message error = 1 and gap = 1;
  - the message-error and word-access interrupts and the broadcast-capable interrupt are raised.
- R4: With transmit/receive = 0, option = 0 and table bit = 0, the outcome is in-form:
  - message error is cleared;
  - the descriptor shows busy-access = 1 and broadcast = the broadcast flag;
  - the info error bits are all 0;
  - the word-access and broadcast-capable interrupts are raised.
- R5: With transmit/receive = 0, option = 0 and table bit = 1, the outcome is illegal:
  - message error is set;
  - the descriptor shows busy-access = 1;
  - the info bits show illegal = 1 and message error = 1;
  - the illegal-command interrupt is raised together with the word-access and broadcast-capable interrupts.
- R6: A valid command with transmit/receive = 1 and no trailing word is the reset outcome:
  - message error is cleared;
  - the descriptor shows busy-access = 0 and broadcast = the broadcast flag;
  - the info error bits are 0;
  - the word-access and broadcast-capable interrupts are raised.
- R7: In the in-form, illegal and reset outcomes, a status transmit is requested exactly when the command is not broadcast. A broadcast command sets the broadcast-received status bit.
- R8: Every non-ignored outcome toggles the descriptor ping-pong bit once. It also records the bus identifier in the info bits and forces the bus-to-bus transfer info bit to 0.
- R9: After a non-broadcast reset outcome, the deferred clear waits for the status-transmission-done strobe, and an end-of-message strobe has no effect on it. When the clear happens, it zeroes the message error, busy and broadcast-received bits, the 16-bit test word, both shutdown bits and the flag inhibit.
- R10: After a broadcast reset outcome, the deferred clear happens on the end-of-message strobe instead.
- R11: All outputs are registered. The done pulse, interrupt strobes and transmit request are high for the one cycle after the command strobe, and never without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_ok | input | 1 | Command word was received valid |
| cmd_tr | input | 1 | Transmit/receive bit of the command |
| cmd_code | input | 5 | Mode code field |
| cmd_bcast | input | 1 | Command was addressed to all terminals |
| cmd_bus | input | 1 | Bus the command arrived on |
| tbl_illegal | input | 1 | Illegal-command table bit for this command |
| opt_undef_inv | input | 1 | Undefined mode codes are treated as invalid |
| extra_word | input | 1 | A contiguous data word followed the command |
| stat_done | input | 1 | Status word transmission finished |
| msg_end | input | 1 | Message finished |
| busy_set | input | 1 | Set the busy status bit |
| shut_set | input | 2 | Set transmitter shutdown, one bit per bus |
| finh_set | input | 1 | Set the terminal-flag inhibit |
| bit_load | input | 1 | Load the test word |
| bit_data | input | 16 | Value for the test word |
| st_merr | output | 1 | Message error status bit |
| st_busy | output | 1 | Busy status bit |
| st_bcr | output | 1 | Broadcast received status bit |
| xmt_shut | output | 2 | Transmitter shutdown state |
| flag_inh | output | 1 | Terminal-flag inhibit |
| bit_word | output | 16 | Built-in-test word |
| ds_busy_acc | output | 1 | Descriptor busy-access bit |
| ds_bcast | output | 1 | Descriptor broadcast bit |
| ds_pingpong | output | 1 | Descriptor ping-pong bit |
| inf_bus | output | 1 | Info: bus identifier |
| inf_merr | output | 1 | Info: message error |
| inf_illegal | output | 1 | Info: illegal command |
| inf_rt2rt | output | 1 | Info: bus-to-bus transfer |
| inf_gap | output | 1 | Info: gap error |
| wr_done | output | 1 | Descriptor and info bits are valid this cycle |
| tx_status | output | 1 | Request to transmit the status word |
| irq_word | output | 1 | Word-access interrupt |
| irq_bcap | output | 1 | Broadcast-capable interrupt |
| irq_illegal | output | 1 | Illegal-command interrupt |
| irq_merr | output | 1 | Message-error interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- the strobes never appear without done;
- a gap outcome never requests status;
- the illegal interrupt always has its info bit;
- each done pulse flips the ping-pong bit;
- a deferred clear leaves the test word and status bits at zero.

The five-way outcome choice is shown only by the bench's sweep over every combination of valid, transmit/receive, broadcast, table, option and trailing-word inputs. The same holds for the choice between the two clear strobes, and for the fact that a foreign mode code leaves everything untouched.

// File: rtl/rt_reset_mc.sv
module rt_reset_mc #(
  parameter logic [4:0] RESET_CODE = 5'b01000,
  parameter int BITW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_stb,
  input  logic            cmd_ok,
  input  logic            cmd_tr,
  input  logic [4:0]      cmd_code,
  input  logic            cmd_bcast,
  input  logic            cmd_bus,
  input  logic            tbl_illegal,
  input  logic            opt_undef_inv,
  input  logic            extra_word,
  input  logic            stat_done,
  input  logic            msg_end,
  input  logic            busy_set,
  input  logic [1:0]      shut_set,
  input  logic            finh_set,
  input  logic            bit_load,
  input  logic [BITW-1:0] bit_data,
  output logic            st_merr,
  output logic            st_busy,
  output logic            st_bcr,
  output logic [1:0]      xmt_shut,
  output logic            flag_inh,
  output logic [BITW-1:0] bit_word,
  output logic            ds_busy_acc,
  output logic            ds_bcast,
  output logic            ds_pingpong,
  output logic            inf_bus,
  output logic            inf_merr,
  output logic            inf_illegal,
  output logic            inf_rt2rt,
  output logic            inf_gap,
  output logic            wr_done,
  output logic            tx_status,
  output logic            irq_word,
  output logic            irq_bcap,
  output logic            irq_illegal,
  output logic            irq_merr
);

  typedef enum logic [2:0] {OC_IGN, OC_GAP, OC_INF, OC_ILL, OC_RST} outcome_t;

  outcome_t oc;
  logic     hit, pend, wait_tx, fire;

  always_comb begin
    if (!cmd_ok)             oc = OC_IGN;
    else if (extra_word)     oc = OC_GAP;
    else if (!cmd_tr)        oc = opt_undef_inv ? OC_IGN : (tbl_illegal ? OC_ILL : OC_INF);
    else                     oc = OC_RST;
  end

  assign hit  = cmd_stb && (cmd_code == RESET_CODE) && (oc != OC_IGN);
  assign fire = pend && (wait_tx ? stat_done : msg_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_merr <= 1'b0; st_busy <= 1'b0; st_bcr <= 1'b0;
      xmt_shut <= '0; flag_inh <= 1'b0; bit_word <= '0;
      ds_busy_acc <= 1'b0; ds_bcast <= 1'b0; ds_pingpong <= 1'b0;
      inf_bus <= 1'b0; inf_merr <= 1'b0; inf_illegal <= 1'b0;
      inf_rt2rt <= 1'b0; inf_gap <= 1'b0;
      wr_done <= 1'b0; tx_status <= 1'b0;
      irq_word <= 1'b0; irq_bcap <= 1'b0; irq_illegal <= 1'b0; irq_merr <= 1'b0;
      pend <= 1'b0; wait_tx <= 1'b0;
    end else begin
      wr_done <= hit;
      irq_word <= hit;
      irq_bcap <= hit;
      irq_illegal <= hit && (oc == OC_ILL);
      irq_merr <= hit && (oc == OC_GAP);
      tx_status <= hit && (oc != OC_GAP) && !cmd_bcast;

      if (busy_set) st_busy <= 1'b1;
      xmt_shut <= xmt_shut | shut_set;
      if (finh_set) flag_inh <= 1'b1;
      if (bit_load) bit_word <= bit_data;

      if (hit) begin
        ds_pingpong <= ~ds_pingpong;
        ds_busy_acc <= (oc != OC_RST);
        ds_bcast    <= (oc == OC_GAP) ? 1'b0 : cmd_bcast;
        inf_bus     <= cmd_bus;
        inf_rt2rt   <= 1'b0;
        inf_merr    <= (oc == OC_GAP) || (oc == OC_ILL);
        inf_illegal <= (oc == OC_ILL);
        inf_gap     <= (oc == OC_GAP);
        st_merr     <= (oc == OC_GAP) || (oc == OC_ILL);
        if (oc != OC_GAP && cmd_bcast) st_bcr <= 1'b1;
        if (oc == OC_RST) begin
          pend    <= 1'b1;
          wait_tx <= !cmd_bcast;
        end
      end

      if (fire) begin
        pend <= 1'b0;
        st_merr <= 1'b0; st_busy <= 1'b0; st_bcr <= 1'b0;
        xmt_shut <= '0; flag_inh <= 1'b0; bit_word <= '0;
      end
    end
  end

  // R11
  strobe_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_status || irq_word || irq_illegal || irq_merr) |-> wr_done);
  // R3
  gap_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_merr |-> (inf_gap && inf_merr && !tx_status && !ds_bcast));
  // R5
  illegal_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_illegal |-> (inf_illegal && inf_merr && st_merr));
  // R8
  pingpong_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (ds_pingpong != $past(ds_pingpong) && !inf_rt2rt));
  // R9
  clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (bit_word == '0 && !flag_inh && xmt_shut == 2'b00 && !pend));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done || $past(cmd_stb));

endmodule

// File: tb/sim_rt_reset_mc.sv
module sim_rt_reset_mc;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_stb = 0, cmd_ok = 0, cmd_tr = 0, cmd_bcast = 0, cmd_bus = 0;
  logic [4:0] cmd_code = 0;
  logic tbl_illegal = 0, opt_undef_inv = 0, extra_word = 0;
  logic stat_done = 0, msg_end = 0, busy_set = 0, finh_set = 0, bit_load = 0;
  logic [1:0] shut_set = 0;
  logic [15:0] bit_data = 0;
  logic st_merr, st_busy, st_bcr, flag_inh, ds_busy_acc, ds_bcast, ds_pingpong;
  logic [1:0] xmt_shut;
  logic [15:0] bit_word;
  logic inf_bus, inf_merr, inf_illegal, inf_rt2rt, inf_gap;
  logic wr_done, tx_status, irq_word, irq_bcap, irq_illegal, irq_merr;

  rt_reset_mc u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic m_me, m_busy, m_bcr, m_inh, m_dpb, m_pend, m_wtx;
  logic [1:0] m_shut;
  logic [15:0] m_bit;
  logic [4:0] m_desc;

  function automatic logic [31:0] stat_vec();
    return {9'd0, m_me, m_busy, m_bcr, m_shut, m_inh, m_bit, m_dpb};
  endfunction
  function automatic logic [31:0] dut_stat();
    return {9'd0, st_merr, st_busy, st_bcr, xmt_shut, flag_inh, bit_word, ds_pingpong};
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_if(input logic tx_phase);
    if (m_pend && (m_wtx == tx_phase)) begin
      m_pend = 0; m_me = 0; m_busy = 0; m_bcr = 0; m_shut = 0; m_inh = 0; m_bit = 0;
    end
  endtask

  initial begin
    m_me = 0; m_busy = 0; m_bcr = 0; m_inh = 0; m_dpb = 0; m_pend = 0; m_wtx = 0;
    m_shut = 0; m_bit = 0;
    @(negedge clk);
    chk("R11 reset outputs", {wr_done, tx_status, irq_word, irq_bcap, irq_illegal, irq_merr}, 0);
    chk("R11 reset state", dut_stat(), 0);
    rst_n = 1;
    tick();
    for (int i = 0; i < 128; i++) begin
      logic ok, tr, bc, il, inv, ex, other;
      int oc;
      logic hit;
      {other, ok, tr, bc, il, inv, ex} = 7'(i);
      busy_set = 1; shut_set = 2'(i + 1); finh_set = i[0]; bit_load = 1; bit_data = 16'hA5C3 ^ 16'(i * 37);
      tick();
      busy_set = 0; shut_set = 0; finh_set = 0; bit_load = 0;
      m_busy = 1; m_shut = m_shut | 2'(i + 1); if (i[0]) m_inh = 1; m_bit = 16'hA5C3 ^ 16'(i * 37);
      chk("R9 preload", dut_stat(), stat_vec());
      cmd_stb = 1; cmd_ok = ok; cmd_tr = tr; cmd_bcast = bc; tbl_illegal = il;
      opt_undef_inv = inv; extra_word = ex; cmd_bus = i[2];
      cmd_code = other ? 5'b00010 : 5'b01000;
      // 0 ignore, 1 gap, 2 in-form, 3 illegal, 4 reset
      oc = !ok ? 0 : ex ? 1 : !tr ? (inv ? 0 : (il ? 3 : 2)) : 4;
      hit = !other && (oc != 0);
      tick();
      cmd_stb = 0;
      if (hit) begin
        m_dpb = ~m_dpb;
        m_me = (oc == 1 || oc == 3);
        if (oc != 1 && bc) m_bcr = 1;
        if (oc == 4) begin m_pend = 1; m_wtx = !bc; end
        m_desc = {1'b1, 1'(oc != 4), 1'(oc == 1 ? 0 : bc), 1'b0, i[2]};
      end
      if (hit) begin
        chk(oc == 1 ? "R3 strobes" : oc == 2 ? "R4 strobes" : oc == 3 ? "R5 strobes" : "R6 R7 strobes",
            {wr_done, tx_status, irq_word, irq_bcap, irq_illegal, irq_merr},
            {1'b1, 1'(oc != 1 && !bc), 1'b1, 1'b1, 1'(oc == 3), 1'(oc == 1)});
        chk(oc == 1 ? "R3 descriptor/info" : oc == 2 ? "R4 descriptor/info" :
            oc == 3 ? "R5 descriptor/info" : "R6 R8 descriptor/info",
            {ds_busy_acc, ds_bcast, inf_merr, inf_illegal, inf_gap, inf_rt2rt, inf_bus},
            {m_desc[3], m_desc[2], 1'(oc == 1 || oc == 3), 1'(oc == 3), 1'(oc == 1), 1'b0, 1'(i[2])});
      end else begin
        chk(other ? "R1 foreign code strobes" : (!ok ? "R1 invalid strobes" : "R2 ignored strobes"),
            {wr_done, tx_status, irq_word, irq_bcap, irq_illegal, irq_merr}, 0);
      end
      chk(hit ? "R7 R8 status after command" : (other || !ok ? "R1 state unchanged" : "R2 state unchanged"),
          dut_stat(), stat_vec());
      msg_end = 1; tick(); msg_end = 0;
      clear_if(1'b0);
      chk(m_wtx ? "R9 end-of-message no clear" : "R10 clear on message end", dut_stat(), stat_vec());
      stat_done = 1; tick(); stat_done = 0;
      clear_if(1'b1);
      chk("R9 clear on status done", dut_stat(), stat_vec());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule